// File: doc/BRIEF.md
# Single-Digit Calculator Entry Sequencer

This block sits behind a key debouncer and turns a stream of clean key codes into a small calculation. It walks through a fixed order of entry steps:

1. a first operand digit,
2. an operator,
3. a second operand digit,
4. the equals key.

On equals it forms the sum, difference or product of the two digits. It then returns to the first step.

Alongside the sequence it drives an 8-bit value for a two-digit display stage. That value shows the first operand once it is entered, then the second operand, then the result.

Keys arrive on a valid/ready channel. The sequencer holds `key_ready` high in every step except the single compute cycle that follows an accepted equals key. A key offered while `key_ready` is low is not consumed. The source must keep `key_valid` and `key_code` stable until a cycle in which both valid and ready are high. Any key whose class does not fit the current step is consumed and discarded.

Top module: `calc_entry_seq`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), the sequencer waits for a first digit, `disp_value` is 0, `calc_error` is 0 and `key_ready` is 1.
- R2: `key_ready` is low for exactly one cycle, the cycle after an equals key is accepted, and high otherwise. A key held valid during that cycle is consumed once, on the next edge.
- R3: In the first-digit step, codes 0 to 9 are accepted as the first operand. `disp_value` shows that digit after the accepting edge, and `calc_error` clears.
- R4: In the operator step, code 10 selects add, 11 selects subtract and 12 selects multiply. `disp_value` keeps the first operand.
- R5: In the second-digit step, codes 0 to 9 are accepted as the second operand, and `disp_value` shows it after the accepting edge.
- R6: After the second digit, only code 13 (equals) starts the computation. Every other code leaves the display and the step unchanged.
- R7: A key whose class does not fit the current step is ignored, and the step and display are unchanged. Codes 14 and 15 are ignored in every step.
- R8: For add and multiply, `disp_value` shows the result (at most 81) one cycle after the compute cycle, that is two edges after equals is accepted.
- R9: For subtract, a non-negative difference is shown with `calc_error` 0. A negative difference shows 0 with `calc_error` 1, which holds until the next first digit is accepted.
- R10: After the compute cycle the sequencer is back in the first-digit step, and a new digit replaces the displayed result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_valid | input | 1 | A key code is offered |
| key_code | input | CODE_W (4) | Key code: 0-9 digit, 10 add, 11 subtract, 12 multiply, 13 equals |
| key_ready | output | 1 | Sequencer can take a key this cycle |
| disp_value | output | DISP_W (8) | Binary value for the display stage |
| calc_error | output | 1 | Last subtraction went negative |

## Verification
The embedded properties hold on every cycle for the handshake and the value bounds:
- `key_ready` never stays low for more than one cycle.
- The compute cycle always returns to the first-digit step.
- The wait-for-equals step never leaves except on an accepted equals key.
- A misfit key in the operator step never moves the step.
- An error always comes with a zero display, and the display never exceeds 81.

Only the bench scenarios can show the rest:
- the arithmetic values for each operator;
- that misfit keys leave the stored operands intact, which shows up later in a correct result;
- that a key held through the compute cycle is consumed exactly once;
- that the error flag clears when a new first digit arrives.

// File: rtl/calc_pkg.sv
package calc_pkg;
  localparam int DIG_W      = 4;
  localparam int DIGIT_TOP  = 9;
  localparam int CODE_ADD   = 10;
  localparam int CODE_SUB   = 11;
  localparam int CODE_MUL   = 12;
  localparam int CODE_EQ    = 13;
  localparam int RESULT_MAX = DIGIT_TOP * DIGIT_TOP;

  typedef enum logic [1:0] {KC_NONE, KC_DIGIT, KC_OPER, KC_EQUALS} key_cls_e;
  typedef enum logic [1:0] {OP_ADD, OP_SUB, OP_MUL} op_e;
  typedef enum logic [2:0] {ST_FIRST, ST_OPER, ST_SECOND, ST_WAIT_EQ, ST_CALC} step_e;
endpackage

// File: rtl/calc_key_class.sv
module calc_key_class
  import calc_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] code,
  output key_cls_e          cls,
  output op_e               op,
  output logic [DIG_W-1:0]  digit
);
  localparam logic [CODE_W-1:0] TOP_DIGIT_C = CODE_W'(DIGIT_TOP);
  localparam logic [CODE_W-1:0] ADD_C       = CODE_W'(CODE_ADD);
  localparam logic [CODE_W-1:0] SUB_C       = CODE_W'(CODE_SUB);
  localparam logic [CODE_W-1:0] MUL_C       = CODE_W'(CODE_MUL);
  localparam logic [CODE_W-1:0] EQ_C        = CODE_W'(CODE_EQ);

  always_comb begin
    cls   = KC_NONE;
    op    = OP_ADD;
    digit = code[DIG_W-1:0];
    if (code <= TOP_DIGIT_C) begin
      cls = KC_DIGIT;
    end else if (code == ADD_C) begin
      cls = KC_OPER;
      op  = OP_ADD;
    end else if (code == SUB_C) begin
      cls = KC_OPER;
      op  = OP_SUB;
    end else if (code == MUL_C) begin
      cls = KC_OPER;
      op  = OP_MUL;
    end else if (code == EQ_C) begin
      cls = KC_EQUALS;
    end
  end
endmodule

// File: rtl/calc_step_ctrl.sv
module calc_step_ctrl
  import calc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     key_valid,
  input  key_cls_e cls,
  output logic     key_ready,
  output logic     load_first,
  output logic     load_op,
  output logic     load_second,
  output logic     compute
);
  step_e st_q, st_d;
  logic  fire;

  assign key_ready = (st_q != ST_CALC);
  assign fire      = key_valid && key_ready;

  always_comb begin
    st_d        = st_q;
    load_first  = 1'b0;
    load_op     = 1'b0;
    load_second = 1'b0;
    compute     = 1'b0;
    case (st_q)
      ST_FIRST: if (fire && cls == KC_DIGIT) begin
        load_first = 1'b1;
        st_d       = ST_OPER;
      end
      ST_OPER: if (fire && cls == KC_OPER) begin
        load_op = 1'b1;
        st_d    = ST_SECOND;
      end
      ST_SECOND: if (fire && cls == KC_DIGIT) begin
        load_second = 1'b1;
        st_d        = ST_WAIT_EQ;
      end
      ST_WAIT_EQ: if (fire && cls == KC_EQUALS) begin
        st_d = ST_CALC;
      end
      ST_CALC: begin
        compute = 1'b1;
        st_d    = ST_FIRST;
      end
      default: st_d = ST_FIRST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_FIRST;
    else     st_q <= st_d;
  end

  // R2
  ready_release_chk: assert property (@(posedge clk) disable iff (rst)
    !key_ready |=> key_ready);

  // R6
  eq_only_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT_EQ && !(fire && cls == KC_EQUALS)) |=> (st_q == ST_WAIT_EQ));

  // R7
  misfit_oper_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && st_q == ST_OPER && cls != KC_OPER) |=> $stable(st_q));

  // R10
  calc_return_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CALC) |=> (st_q == ST_FIRST));
endmodule

// File: rtl/calc_alu.sv
module calc_alu
  import calc_pkg::*;
#(
  parameter int DISP_W = 8
) (
  input  logic [DIG_W-1:0]  a,
  input  logic [DIG_W-1:0]  b,
  input  op_e               op,
  output logic [DISP_W-1:0] value,
  output logic              negative
);
  localparam int PAD_W = DISP_W - DIG_W;

  logic [DISP_W-1:0] a_ext, b_ext;

  assign a_ext = {{PAD_W{1'b0}}, a};
  assign b_ext = {{PAD_W{1'b0}}, b};

  always_comb begin
    negative = 1'b0;
    case (op)
      OP_ADD: value = a_ext + b_ext;
      OP_SUB: begin
        if (a < b) begin
          value    = '0;
          negative = 1'b1;
        end else begin
          value = a_ext - b_ext;
        end
      end
      OP_MUL:  value = a_ext * b_ext;
      default: value = '0;
    endcase
  end
endmodule

// File: rtl/calc_datapath.sv
module calc_datapath
  import calc_pkg::*;
#(
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_first,
  input  logic              load_op,
  input  logic              load_second,
  input  logic              compute,
  input  logic [DIG_W-1:0]  digit,
  input  op_e               op,
  output logic [DISP_W-1:0] disp_value,
  output logic              calc_error
);
  localparam int PAD_W = DISP_W - DIG_W;

  logic [DIG_W-1:0]  a_q, b_q;
  op_e               op_q;
  logic [DISP_W-1:0] alu_val;
  logic              alu_neg;

  calc_alu #(.DISP_W(DISP_W)) u_alu (
    .a        (a_q),
    .b        (b_q),
    .op       (op_q),
    .value    (alu_val),
    .negative (alu_neg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q        <= '0;
      b_q        <= '0;
      op_q       <= OP_ADD;
      disp_value <= '0;
      calc_error <= 1'b0;
    end else begin
      if (load_first) begin
        a_q        <= digit;
        disp_value <= {{PAD_W{1'b0}}, digit};
        calc_error <= 1'b0;
      end
      if (load_op) op_q <= op;
      if (load_second) begin
        b_q        <= digit;
        disp_value <= {{PAD_W{1'b0}}, digit};
      end
      if (compute) begin
        disp_value <= alu_val;
        calc_error <= alu_neg;
      end
    end
  end

  // R9
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    calc_error |-> (disp_value == '0));

  // R8
  disp_range_chk: assert property (@(posedge clk) disable iff (rst)
    disp_value <= DISP_W'(RESULT_MAX));

  // R3
  digit_show_chk: assert property (@(posedge clk) disable iff (rst)
    load_first |=> (disp_value == {{PAD_W{1'b0}}, $past(digit)}));
endmodule

// File: rtl/calc_entry_seq.sv
module calc_entry_seq
  import calc_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_valid,
  input  logic [CODE_W-1:0] key_code,
  output logic              key_ready,
  output logic [DISP_W-1:0] disp_value,
  output logic              calc_error
);
  key_cls_e         cls;
  op_e              op;
  logic [DIG_W-1:0] digit;
  logic             load_first, load_op, load_second, compute;

  calc_key_class #(.CODE_W(CODE_W)) u_class (
    .code  (key_code),
    .cls   (cls),
    .op    (op),
    .digit (digit)
  );

  calc_step_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .key_valid   (key_valid),
    .cls         (cls),
    .key_ready   (key_ready),
    .load_first  (load_first),
    .load_op     (load_op),
    .load_second (load_second),
    .compute     (compute)
  );

  calc_datapath #(.DISP_W(DISP_W)) u_data (
    .clk         (clk),
    .rst         (rst),
    .load_first  (load_first),
    .load_op     (load_op),
    .load_second (load_second),
    .compute     (compute),
    .digit       (digit),
    .op          (op),
    .disp_value  (disp_value),
    .calc_error  (calc_error)
  );
endmodule

// File: tb/calc_entry_seq_test.sv
module calc_entry_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       key_valid = 1'b0;
  logic [3:0] key_code = '0;
  logic       key_ready;
  logic [7:0] disp_value;
  logic       calc_error;

  always #2.5 clk = ~clk;

  calc_entry_seq uut (
    .clk(clk), .rst(rst), .key_valid(key_valid), .key_code(key_code),
    .key_ready(key_ready), .disp_value(disp_value), .calc_error(calc_error)
  );

  typedef struct {
    int    due;
    int    disp;
    bit    err;
    bit    rdy;
    string req;
  } item_t;

  item_t exp_q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;

  int m_disp = 0, m_a = 0, m_b = 0, m_op = 10;
  bit m_err = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int due, input int d, input bit e, input bit r, input string req);
    item_t it;
    it.due = due; it.disp = d; it.err = e; it.rdy = r; it.req = req;
    exp_q.push_back(it);
  endtask

  // monitor: pop expected items when due and compare
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      item_t it;
      it = exp_q.pop_front();
      checks++;
      if (disp_value !== 8'(it.disp) || calc_error !== it.err || key_ready !== it.rdy) begin
        fails++;
        $display("FAIL %s: disp=%0d err=%0b rdy=%0b expected disp=%0d err=%0b rdy=%0b",
                 it.req, disp_value, calc_error, key_ready, it.disp, it.err, it.rdy);
      end
    end
  end

  // drive one key from a negedge; returns the cycle number after the consuming edge
  task automatic drive(input int code, output int acc);
    key_valid = 1'b1;
    key_code  = 4'(code);
    while (!key_ready) @(negedge clk);
    acc = cyc + 1;
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic key_first(input int d);
    int acc;
    drive(d, acc);
    m_a = d; m_disp = d; m_err = 0;
    push(acc, m_disp, m_err, 1, "R3");
  endtask

  task automatic key_oper(input int c);
    int acc;
    drive(c, acc);
    m_op = c;
    push(acc, m_disp, m_err, 1, "R4");
  endtask

  task automatic key_second(input int d);
    int acc;
    drive(d, acc);
    m_b = d; m_disp = d;
    push(acc, m_disp, m_err, 1, "R5");
  endtask

  task automatic key_equals();
    int acc;
    int res;
    bit neg;
    drive(13, acc);
    push(acc, m_disp, m_err, 0, "R2");
    neg = 0;
    if (m_op == 10) res = m_a + m_b;
    else if (m_op == 12) res = m_a * m_b;
    else if (m_a >= m_b) res = m_a - m_b;
    else begin res = 0; neg = 1; end
    m_disp = res; m_err = neg;
    push(acc + 1, m_disp, m_err, 1, (m_op == 11) ? "R9" : "R8");
  endtask

  task automatic key_ignored(input int c, input string req);
    int acc;
    drive(c, acc);
    push(acc, m_disp, m_err, 1, req);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    checks++;
    if (disp_value !== 8'd0 || calc_error !== 1'b0 || key_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1: disp=%0d err=%0b rdy=%0b expected disp=0 err=0 rdy=1",
               disp_value, calc_error, key_ready);
    end

    // 3 + 4
    key_first(3); key_oper(10); key_second(4); key_equals();

    // misfit keys in every step (R7, R6), then 9 * 9 = 81 (R8)
    key_ignored(10, "R7"); key_ignored(13, "R7"); key_ignored(15, "R7");
    key_first(9);
    key_ignored(5, "R7"); key_ignored(13, "R7"); key_ignored(14, "R7");
    key_oper(12);
    key_ignored(11, "R7"); key_ignored(13, "R7");
    key_second(9);
    key_ignored(2, "R6"); key_ignored(10, "R6"); key_ignored(15, "R6");
    key_equals();

    // 8 - 3 non-negative (R9)
    key_first(8); key_oper(11); key_second(3); key_equals();

    // 2 - 7 negative, then digit held through compute cycle (R9, R2, R10)
    key_first(2); key_oper(11); key_second(7); key_equals();
    key_first(6);
    key_oper(12); key_second(0); key_equals();

    // boundary sums: 0 + 0, 9 + 9
    key_first(0); key_oper(10); key_second(0); key_equals();
    key_first(9); key_oper(10); key_second(9); key_equals();
    // equal operands subtract to zero without error (R9)
    key_first(5); key_oper(11); key_second(5); key_equals();

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
    end
    summary();
    $finish;
  end
endmodule